// File: doc/BRIEF.md
# Gray-Coded Ramp Conversion Capture

This block is the digital back end of a per-pixel single-slope converter. A counter shared by the array advances once for every count strobe, the same strobe that steps the reference ramp, and it broadcasts its value in Gray code. The pixel comparator is seen here only as a digital level. The first change of that level inside a conversion window freezes the Gray code present at that moment into a result bank.

Two result banks work in ping-pong fashion. A window-start pulse closes the bank being written, clears the counter and makes the other bank the write target. The closed bank then sits on the read port, converted to binary, while the next conversion runs. A window with no comparator change stores the full-scale code and marks the result as overflowed. A mode input, latched at each window start, selects the counting range. Full range uses all 8 code bits. Narrow range uses only the low 6 bits, which is the range a fast event-count conversion can cover.

Top module: `gray_ramp_capture`

## Requirements
- R1: After reset the read port shows rd_valid_o=0, rd_ovf_o=0 and rd_data_o=0, and cnt_gray_o is 0.
- R2: Each cycle with cnt_stb_i=1 and win_start_i=0 adds one to the count. cnt_gray_o always carries the Gray form of the count, n ^ (n>>1).
- R3: The count saturates at the full-scale value of the current mode. That value is 255 when the mode is 0 (full range) and 63 when the mode is 1 (narrow range).
- R4: A cycle with win_start_i=1 sets the count to 0, and this takes precedence over a strobe in the same cycle. It also latches count_mode_i as the mode of the window that is opening.
- R5: A comparator toggle means that cmp_i differs from its value one cycle earlier, in either direction. The first toggle in a window stores the Gray code present before the clock edge. If a strobe falls in the same cycle, the stored value is the one from before that step.
- R6: Toggles after the first one in a window are ignored. A toggle in the same cycle as win_start_i is also ignored.
- R7: If a window closes with no captured toggle, its bank holds the full-scale code of that window's mode and reads back with rd_ovf_o=1.
- R8: The read port shows the bank not currently written, converted from Gray to binary. rd_valid_o=1 once that bank has closed a window. The read values stay constant for the whole of the following window.
- R9: In narrow mode a captured result never exceeds 63. Results below 63 read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_start_i | input | 1 | Window boundary pulse: close bank, swap banks, clear counter |
| count_mode_i | input | 1 | 0 full 8-bit range, 1 narrow 6-bit range; latched at window start |
| cnt_stb_i | input | 1 | Count strobe shared with the reference ramp |
| cmp_i | input | 1 | Comparator level |
| cnt_gray_o | output | 8 | Broadcast Gray-coded count |
| rd_data_o | output | 8 | Binary value of the readable bank |
| rd_valid_o | output | 1 | Readable bank holds a closed result |
| rd_ovf_o | output | 1 | Readable bank result is full-scale with no comparator toggle |

## Verification
Two events can land in the same cycle: the comparator toggle that triggers a capture and a count strobe that moves the code. The bench raises both in one cycle after a known number of strobes. After the bank swap it expects the read port to show the count from before that step, not one higher. A second coincidence is a toggle in the window-start cycle. The bench produces one, lets the rest of the window run with no further toggle, and expects the full-scale value with the overflow flag set.

// File: rtl/gray_cap_pkg.sv
package gray_cap_pkg;
  localparam int CODE_W   = 8;
  localparam int NARROW_W = 6;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t FULL_MAX   = code_t'((1 << CODE_W) - 1);
  localparam code_t NARROW_MAX = code_t'((1 << NARROW_W) - 1);

  function automatic code_t bin2gray(input code_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic code_t gray2bin(input code_t g);
    code_t b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/gray_ramp_counter.sv
module gray_ramp_counter
  import gray_cap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  win_start_i,
  input  logic  count_mode_i,
  input  logic  cnt_stb_i,
  output code_t gray_o,
  output code_t full_gray_o
);
  code_t bin_q;
  logic  mode_q;
  code_t lim;

  assign lim         = mode_q ? NARROW_MAX : FULL_MAX;
  assign gray_o      = bin2gray(bin_q);
  assign full_gray_o = bin2gray(lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      mode_q <= 1'b0;
    end else if (win_start_i) begin
      bin_q  <= '0;
      mode_q <= count_mode_i;
    end else if (cnt_stb_i && bin_q != lim) begin
      bin_q <= bin_q + 1'b1;
    end
  end

  p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_start_i |=> gray_o == '0);
  p_gray_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_start_i |=> $countones(gray_o ^ $past(gray_o)) <= 1);
  p_cnt_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gray2bin(gray_o) <= lim);
endmodule

// File: rtl/toggle_capture.sv
module toggle_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_start_i,
  input  logic cmp_i,
  output logic hit_o,
  output logic taken_o
);
  logic cmp_q;

  // first edge of the window only; window-start cycle consumes any edge
  assign hit_o = (cmp_i ^ cmp_q) & ~win_start_i & ~taken_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= 1'b0;
      taken_o <= 1'b0;
    end else begin
      cmp_q <= cmp_i;
      if (win_start_i) taken_o <= 1'b0;
      else if (hit_o)  taken_o <= 1'b1;
    end
  end

  p_hit_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !win_start_i) |=> !hit_o);
endmodule

// File: rtl/result_bank_pair.sv
module result_bank_pair
  import gray_cap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  win_start_i,
  input  logic  hit_i,
  input  logic  taken_i,
  input  code_t gray_i,
  input  code_t full_gray_i,
  output code_t rd_gray_o,
  output logic  rd_valid_o,
  output logic  rd_ovf_o
);
  localparam int NBANK = 2;
  logic  sel_q;
  code_t code_q  [NBANK];
  logic  valid_q [NBANK];
  logic  ovf_q   [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[b]  <= '0;
        valid_q[b] <= 1'b0;
        ovf_q[b]   <= 1'b0;
      end else if (win_start_i) begin
        if (sel_q == 1'(b)) begin
          valid_q[b] <= 1'b1;
          if (!taken_i) begin
            code_q[b] <= full_gray_i;
            ovf_q[b]  <= 1'b1;
          end
        end else begin
          valid_q[b] <= 1'b0;
          ovf_q[b]   <= 1'b0;
        end
      end else if (hit_i && sel_q == 1'(b)) begin
        code_q[b] <= gray_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sel_q <= 1'b0;
    else if (win_start_i) sel_q <= ~sel_q;
  end

  assign rd_gray_o  = code_q[~sel_q];
  assign rd_valid_o = valid_q[~sel_q];
  assign rd_ovf_o   = ovf_q[~sel_q];

  p_rd_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_start_i |=> $stable(rd_gray_o) && $stable(rd_ovf_o) && $stable(rd_valid_o));
  p_ovf_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ovf_o |-> (rd_gray_o == bin2gray(FULL_MAX) || rd_gray_o == bin2gray(NARROW_MAX)));
endmodule

// File: rtl/gray_ramp_capture.sv
module gray_ramp_capture
  import gray_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_start_i,
  input  logic              count_mode_i,
  input  logic              cnt_stb_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] cnt_gray_o,
  output logic [CODE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_ovf_o
);
  code_t gray, full_gray, rd_gray;
  logic  hit, taken;

  gray_ramp_counter i_cnt (
    .clk_i, .rst_ni, .win_start_i, .count_mode_i, .cnt_stb_i,
    .gray_o(gray), .full_gray_o(full_gray)
  );

  toggle_capture i_cap (
    .clk_i, .rst_ni, .win_start_i, .cmp_i, .hit_o(hit), .taken_o(taken)
  );

  result_bank_pair i_banks (
    .clk_i, .rst_ni, .win_start_i, .hit_i(hit), .taken_i(taken),
    .gray_i(gray), .full_gray_i(full_gray),
    .rd_gray_o(rd_gray), .rd_valid_o, .rd_ovf_o
  );

  assign cnt_gray_o = gray;
  assign rd_data_o  = gray2bin(rd_gray);

  p_valid_after_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ovf_o |-> rd_valid_o);
endmodule

// File: tb/test_gray_ramp_capture.sv
module test_gray_ramp_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic win = 0, mode = 0, stb = 0, cmp = 0;
  logic [7:0] gray_o, rd_data;
  logic rd_valid, rd_ovf;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gray_ramp_capture i_gray_ramp_capture (
    .clk_i(clk), .rst_ni(rst_n), .win_start_i(win), .count_mode_i(mode),
    .cnt_stb_i(stb), .cmp_i(cmp), .cnt_gray_o(gray_o), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rd_ovf_o(rd_ovf)
  );

  function automatic logic [7:0] g(input int n);
    logic [7:0] v = 8'(n);
    return v ^ (v >> 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic win_pulse(input logic m);
    mode = m; win = 1; tick(); win = 0;
  endtask
  task automatic strobes(input int n);
    stb = 1; repeat (n) tick(); stb = 0;
  endtask
  task automatic toggle();
    cmp = ~cmp; tick();
  endtask

  task automatic t_reset();
    chk("R1 valid", rd_valid, 0); chk("R1 ovf", rd_ovf, 0);
    chk("R1 data", rd_data, 0);   chk("R1 gray", gray_o, 0);
  endtask

  task automatic t_basic_and_pingpong();
    win_pulse(0);
    chk("R4 clear", gray_o, 0);
    strobes(37);
    chk("R2 gray", gray_o, g(37));
    toggle(); strobes(5);
    win_pulse(0);
    chk("R8 data", rd_data, 37); chk("R8 valid", rd_valid, 1); chk("R7 no ovf", rd_ovf, 0);
    strobes(10); toggle(); strobes(4);
    chk("R8 held", rd_data, 37);
    win_pulse(0);
    chk("R5 second", rd_data, 10);
  endtask

  task automatic t_later_toggles();
    strobes(10); toggle(); strobes(10); toggle(); toggle();
    win_pulse(0);
    chk("R6 first only", rd_data, 10);
  endtask

  task automatic t_overflow_full();
    strobes(300);
    chk("R3 sat 255", gray_o, g(255));
    win_pulse(1);
    chk("R7 full data", rd_data, 255); chk("R7 full ovf", rd_ovf, 1);
  endtask

  task automatic t_narrow();
    strobes(100);
    chk("R3 sat 63", gray_o, g(63));
    win_pulse(1);
    chk("R9 ovf data", rd_data, 63); chk("R7 narrow ovf", rd_ovf, 1);
    strobes(50); toggle();
    win_pulse(0);
    chk("R9 narrow", rd_data, 50); chk("R9 ovf clear", rd_ovf, 0);
  endtask

  task automatic t_coincident();
    strobes(5);
    stb = 1; cmp = ~cmp; tick(); stb = 0;
    chk("R2 step", gray_o, g(6));
    strobes(3);
    win_pulse(0);
    chk("R5 coincident", rd_data, 5);
  endtask

  task automatic t_toggle_at_start();
    mode = 0; win = 1; cmp = ~cmp; stb = 1; tick(); win = 0; stb = 0;
    chk("R4 start wins", gray_o, 0);
    strobes(20);
    win_pulse(0);
    chk("R6 start toggle ignored", rd_ovf, 1);
    chk("R7 start data", rd_data, 255);
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_basic_and_pingpong();
    t_later_toggles();
    t_overflow_full();
    t_narrow();
    t_coincident();
    t_toggle_at_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule